// File: doc/BRIEF.md
# PRBS and Clock-Pattern Stream Generator

This block produces a test data stream on a parallel streaming source that uses valid/ready handshaking. Each beat holds four symbols. A build-time parameter sets the symbol width to 8 or 10 bits, so a beat is 32 or 40 bits wide. The top bit of a beat is the first bit in time. Within a beat the most significant symbol goes first, and within a symbol the most significant bit goes first.

A small register port controls the generator at run time. Through it, software can start and stop the stream and choose one of six patterns: four pseudo-random sequences and two clock-like square waves. It can also request a one-shot single-bit error and arm a preamble burst. The preamble sends a chosen character for a set number of beats before the pattern begins, so a receiver can find word boundaries. While the generator is stopped, it drives a fixed alternating idle word.

Top module: `prbs_stream_gen`

## Requirements
- R1: After reset, out_valid_o is 0 and all four registers read back as zero. These are offset 0 (bit 0: run), offset 1 (bits 2:0: pattern), offset 2 (bit 0: error request) and offset 3 (bit 0: preamble on, bits 15:8: beat count, bits 16+SYM_W-1:16: preamble character).
- R2: While stopped, out_valid_o is 0 and out_data_o carries an alternating word with bit 0 = 1, every even bit 1 and every odd bit 0. This is 0x55555555 for a 32-bit beat.
- R3: Pattern codes 0 to 3 select pseudo-random sequences with polynomials x^7+x^6+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1. Each register starts from all ones. At each serial step the register shifts left, and the XOR of bits N-1 and M-1 becomes both the new bit 0 and the next output bit. One beat holds BEAT_W consecutive output bits, with the first bit placed in the beat's top bit.
- R4: The sequence advances by one beat only when a beat is accepted, meaning out_valid_o and out_ready_i are both 1. While out_ready_i is 0, out_data_o holds its value.
- R5: Pattern code 4 repeats 1010… in every symbol, giving 0xAAAAAAAA for a 32-bit beat. Pattern code 5 sets the upper half of each symbol to ones and the lower half to zeros, giving 0xF0F0F0F0 for a 32-bit beat.
- R6: A write of pattern code 6 or 7 is ignored, and the stored pattern does not change.
- R7: A pattern write made while running restarts the selected sequence from its all-ones seed on the next beat.
- R8: Writing 1 to bit 0 of offset 2 inverts bit 0 of the next accepted beat only. The request reads back as 1 through any stalled cycles and as 0 once that beat is accepted.
- R9: An error request made while stopped lands on the first beat after the stream starts.
- R10: If the preamble is on with a count N greater than 0, the first N accepted beats after a start carry the preamble character in all four symbols, and the selected pattern follows from its seed. A count of 0 sends no preamble.
- R11: Writes to offset 3 are ignored while running.
- R12: Writing 1 to bit 0 of offset 0 makes out_valid_o go high on the next cycle. Writing 0 returns the output to the idle word on the next cycle. A later start begins again from the seed and the preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset for both read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| out_valid_o | output | 1 | Beat valid |
| out_ready_i | input | 1 | Sink ready |
| out_data_o | output | BEAT_W | Beat data, first bit in time at the top |

## Verification
Every pattern code is run with random backpressure. This separates advancing on acceptance from advancing every cycle, and the hold under stall shows up on any stalled beat. Preamble counts of 0, small values and 255 are mixed with error requests made before and during a run. This tells whether the inverted bit lands on exactly one beat and whether the preamble-to-pattern handover starts from the seed. Mid-run pattern switches check the reseed. Directed writes check the ignored cases: illegal pattern codes and preamble writes while running.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic [2:0] {
    PAT_P7  = 3'd0,
    PAT_P15 = 3'd1,
    PAT_P23 = 3'd2,
    PAT_P31 = 3'd3,
    PAT_HF  = 3'd4,
    PAT_LF  = 3'd5
  } pat_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PRE  = 2'd1,
    SQ_RUN  = 2'd2
  } seq_e;

  localparam logic [1:0] ADDR_RUN = 2'd0;
  localparam logic [1:0] ADDR_PAT = 2'd1;
  localparam logic [1:0] ADDR_ERR = 2'd2;
  localparam logic [1:0] ADDR_PRE = 2'd3;

  localparam int NUM_LFSR = 4;
  localparam int CNT_W    = 8;
endpackage

// File: rtl/pgen_lane.sv
module pgen_lane #(
  parameter int N = 7,
  parameter int M = 6,
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         seed_i,
  input  logic         adv_i,
  output logic [W-1:0] beat_o
);
  logic [N-1:0] st_q, st_n;
  logic         fb;

  // unroll W serial steps; first bit lands in the top of the beat
  always_comb begin
    st_n   = st_q;
    beat_o = '0;
    fb     = 1'b0;
    for (int i = 0; i < W; i++) begin
      fb            = st_n[N-1] ^ st_n[M-1];
      st_n          = {st_n[N-2:0], fb};
      beat_o[W-1-i] = fb;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '1;
    else if (seed_i) st_q <= '1;
    else if (adv_i)  st_q <= st_n;
  end

  // R3: a maximal-length register never falls into the all-zero lock state
  p_lfsr_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
endmodule

// File: rtl/pgen_regs.sv
module pgen_regs
  import pgen_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             accept_i,
  output logic [31:0]      rdata_o,
  output logic             run_o,
  output logic             start_o,
  output logic             stop_o,
  output pat_e             pat_o,
  output logic             pat_wr_o,
  output logic             err_o,
  output logic             pre_en_o,
  output logic [CNT_W-1:0] pre_cnt_o,
  output logic [SYM_W-1:0] pre_char_o
);
  logic err_set;

  assign start_o  = we_i && addr_i == ADDR_RUN && wdata_i[0] && !run_o;
  assign stop_o   = we_i && addr_i == ADDR_RUN && !wdata_i[0] && run_o;
  assign pat_wr_o = we_i && addr_i == ADDR_PAT && wdata_i[2:0] <= 3'd5;
  assign err_set  = we_i && addr_i == ADDR_ERR && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o      <= 1'b0;
      pat_o      <= PAT_P7;
      pre_en_o   <= 1'b0;
      pre_cnt_o  <= '0;
      pre_char_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_RUN: run_o <= wdata_i[0];
        ADDR_PAT: if (pat_wr_o) pat_o <= pat_e'(wdata_i[2:0]);
        ADDR_PRE: if (!run_o) begin
          pre_en_o   <= wdata_i[0];
          pre_cnt_o  <= wdata_i[15:8];
          pre_char_o <= wdata_i[16 +: SYM_W];
        end
        default: ;
      endcase
    end
  end

  // a new request wins over consumption of the pending one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_o <= 1'b0;
    else if (err_set)  err_o <= 1'b1;
    else if (accept_i) err_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_RUN: rdata_o[0]   = run_o;
      ADDR_PAT: rdata_o[2:0] = pat_o;
      ADDR_ERR: rdata_o[0]   = err_o;
      default: begin
        rdata_o[0]          = pre_en_o;
        rdata_o[15:8]       = pre_cnt_o;
        rdata_o[16 +: SYM_W] = pre_char_o;
      end
    endcase
  end

  p_err_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && !err_set |=> !err_o);

  p_pre_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> $stable({pre_en_o, pre_cnt_o, pre_char_o}));
endmodule

// File: rtl/pgen_seq.sv
module pgen_seq
  import pgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             pre_en_i,
  input  logic [CNT_W-1:0] pre_cnt_i,
  input  logic             accept_i,
  output logic             valid_o,
  output logic             in_pre_o,
  output logic             in_run_o
);
  seq_e             st_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      left_q <= '0;
    end else if (stop_i) begin
      st_q <= SQ_IDLE;
    end else if (start_i) begin
      st_q   <= (pre_en_i && pre_cnt_i != '0) ? SQ_PRE : SQ_RUN;
      left_q <= pre_cnt_i;
    end else if (st_q == SQ_PRE && accept_i) begin
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) st_q <= SQ_RUN;
    end
  end

  assign valid_o  = st_q != SQ_IDLE;
  assign in_pre_o = st_q == SQ_PRE;
  assign in_run_o = st_q == SQ_RUN;

  p_pre_left_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pre_o |-> left_q != '0);

  p_start_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  p_stop_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !valid_o);
endmodule

// File: rtl/prbs_stream_gen.sv
module prbs_stream_gen
  import pgen_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int NUM_SYM = 4,
  localparam int BEAT_W = SYM_W * NUM_SYM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BEAT_W-1:0] out_data_o
);
  function automatic logic [SYM_W-1:0] hf_sym();
    logic [SYM_W-1:0] r;
    for (int i = 0; i < SYM_W; i++) r[i] = ((SYM_W - 1 - i) % 2) == 0;
    return r;
  endfunction

  function automatic logic [SYM_W-1:0] lf_sym();
    logic [SYM_W-1:0] r;
    for (int i = 0; i < SYM_W; i++) r[i] = i >= SYM_W / 2;
    return r;
  endfunction

  function automatic logic [BEAT_W-1:0] idle_word();
    logic [BEAT_W-1:0] r;
    for (int i = 0; i < BEAT_W; i++) r[i] = (i % 2) == 0;
    return r;
  endfunction

  localparam logic [BEAT_W-1:0] HF_BEAT   = {NUM_SYM{hf_sym()}};
  localparam logic [BEAT_W-1:0] LF_BEAT   = {NUM_SYM{lf_sym()}};
  localparam logic [BEAT_W-1:0] IDLE_BEAT = idle_word();

  logic             accept, start, stop, run_q, pat_wr, err_q;
  logic             pre_en, in_pre, in_run, valid;
  logic [CNT_W-1:0] pre_cnt;
  logic [SYM_W-1:0] pre_char;
  pat_e             pat;
  logic             reseed;
  logic [BEAT_W-1:0] lane_beat [NUM_LFSR];
  logic [BEAT_W-1:0] base;

  assign accept = valid && out_ready_i;
  assign reseed = !valid || pat_wr;

  pgen_regs #(.SYM_W(SYM_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .accept_i   (accept),
    .rdata_o    (reg_rdata_o),
    .run_o      (run_q),
    .start_o    (start),
    .stop_o     (stop),
    .pat_o      (pat),
    .pat_wr_o   (pat_wr),
    .err_o      (err_q),
    .pre_en_o   (pre_en),
    .pre_cnt_o  (pre_cnt),
    .pre_char_o (pre_char)
  );

  pgen_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .stop_i    (stop),
    .pre_en_i  (pre_en),
    .pre_cnt_i (pre_cnt),
    .accept_i  (accept),
    .valid_o   (valid),
    .in_pre_o  (in_pre),
    .in_run_o  (in_run)
  );

  for (genvar g = 0; g < NUM_LFSR; g++) begin : g_lane
    localparam int LN = (g == 0) ? 7 : (g == 1) ? 15 : (g == 2) ? 23 : 31;
    localparam int LM = (g == 0) ? 6 : (g == 1) ? 14 : (g == 2) ? 18 : 28;
    pgen_lane #(.N(LN), .M(LM), .W(BEAT_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .seed_i (reseed),
      .adv_i  (accept && in_run && pat == pat_e'(g)),
      .beat_o (lane_beat[g])
    );
  end

  always_comb begin
    case (pat)
      PAT_P7:  base = lane_beat[0];
      PAT_P15: base = lane_beat[1];
      PAT_P23: base = lane_beat[2];
      PAT_P31: base = lane_beat[3];
      PAT_HF:  base = HF_BEAT;
      PAT_LF:  base = LF_BEAT;
      default: base = IDLE_BEAT;
    endcase
  end

  always_comb begin
    if (!valid) out_data_o = IDLE_BEAT;
    else out_data_o = (in_pre ? {NUM_SYM{pre_char}} : base)
                      ^ {{(BEAT_W-1){1'b0}}, err_q};
  end

  assign out_valid_o = valid;

  p_stall_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !reg_we_i |=> out_valid_o && $stable(out_data_o));

  p_run_match_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> run_q);
endmodule

// File: tb/prbs_stream_gen_tb.sv
`timescale 1ns/1ps
module prbs_stream_gen_tb;
  localparam int SYM_W = 8;
  localparam int BW    = 4 * SYM_W;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          valid;
  logic          ready = 1'b0;
  logic [BW-1:0] data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  prbs_stream_gen #(.SYM_W(SYM_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .out_valid_o(valid),
    .out_ready_i(ready), .out_data_o(data)
  );

  // model state
  int          m_pat;
  logic [31:0] m_st;
  int          m_pre_left;
  bit          m_err;
  bit          m_pre_en;
  int          m_pre_cnt;
  logic [SYM_W-1:0] m_char;
  string       next_tag;

  localparam logic [BW-1:0] IDLE_W = 32'h5555_5555;
  localparam logic [BW-1:0] HF_W   = 32'hAAAA_AAAA;
  localparam logic [BW-1:0] LF_W   = 32'hF0F0_F0F0;

  function automatic int tap_n(int p);
    return (p == 0) ? 7 : (p == 1) ? 15 : (p == 2) ? 23 : 31;
  endfunction
  function automatic int tap_m(int p);
    return (p == 0) ? 6 : (p == 1) ? 14 : (p == 2) ? 18 : 28;
  endfunction

  // returns {next_state, beat}
  function automatic logic [BW+31:0] prbs_step(logic [31:0] st, int n, int m);
    logic [BW-1:0] bt;
    logic [31:0]   mask;
    logic          b;
    mask = (n == 32) ? '1 : ((32'h1 << n) - 32'h1);
    for (int k = 0; k < BW; k++) begin
      b = st[n-1] ^ st[m-1];
      st = ((st << 1) | {31'd0, b}) & mask;
      bt[BW-1-k] = b;
    end
    return {st, bt};
  endfunction

  function automatic logic [BW-1:0] model_beat();
    logic [BW-1:0] r;
    logic [BW+31:0] s;
    if (m_pre_left > 0) r = {4{m_char}};
    else if (m_pat == 4) r = HF_W;
    else if (m_pat == 5) r = LF_W;
    else begin
      s = prbs_step(m_st, tap_n(m_pat), tap_m(m_pat));
      r = s[BW-1:0];
    end
    return r ^ {{(BW-1){1'b0}}, m_err};
  endfunction

  task automatic model_accept();
    logic [BW+31:0] s;
    if (m_pre_left > 0) m_pre_left--;
    else if (m_pat < 4) begin
      s = prbs_step(m_st, tap_n(m_pat), tap_m(m_pat));
      m_st = s[BW+31:BW];
    end
    m_err = 0;
  endtask

  task automatic chk(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    ready = 1'b0;
    addr  = a;
    wdata = d;
    we    = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    addr = a;
    #1;
    chk(tag, BW'(rdata), BW'(exp));
  endtask

  task automatic start_stream();
    wr(2'd0, 32'd1);
    m_st = '1;
    m_pre_left = m_pre_en ? m_pre_cnt : 0;
  endtask

  task automatic run_beats(int n, int stall_pct);
    bit r;
    bit stalled = 0;
    string tag;
    for (int i = 0; i < n; i++) begin
      r = ($urandom % 100) >= stall_pct;
      ready = r;
      if (next_tag != "") tag = next_tag;
      else if (stalled) tag = "R4";
      else if (m_pre_left > 0) tag = "R10";
      else if (m_err) tag = "R8";
      else if (m_pat >= 4) tag = "R5";
      else tag = "R3";
      chk({tag, " valid"}, BW'(valid), BW'(1));
      chk(tag, data, model_beat());
      @(negedge clk);
      if (r) begin
        model_accept();
        next_tag = "";
      end
      stalled = !r;
    end
    ready = 1'b0;
  endtask

  task automatic cfg_pre(bit en, int cnt, logic [SYM_W-1:0] ch);
    wr(2'd3, {8'd0, ch, cnt[7:0], 7'd0, en});
    m_pre_en = en; m_pre_cnt = cnt; m_char = ch;
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_pat = 0; m_st = '1; m_pre_left = 0; m_err = 0;
    m_pre_en = 0; m_pre_cnt = 0; m_char = '0; next_tag = "";
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 / R2 reset and idle
    chk("R1 valid", BW'(valid), BW'(0));
    chk("R2 idle", data, IDLE_W);
    for (int a = 0; a < 4; a++) rd(a[1:0], 32'd0, "R1 reg");

    // R5 clock patterns, exact words
    wr(2'd1, 32'd4); m_pat = 4;
    start_stream();
    chk("R12 valid", BW'(valid), BW'(1));
    chk("R5 hf", data, HF_W);
    wr(2'd1, 32'd5); m_pat = 5;
    chk("R5 lf", data, LF_W);
    run_beats(6, 30);
    wr(2'd0, 32'd0);
    chk("R12 stop valid", BW'(valid), BW'(0));
    chk("R12 stop idle", data, IDLE_W);

    // R6 illegal codes
    wr(2'd1, 32'd7);
    rd(2'd1, 32'd5, "R6 code7");
    wr(2'd1, 32'd6);
    rd(2'd1, 32'd5, "R6 code6");

    // R11 preamble locked while running
    cfg_pre(1, 3, 8'h3C);
    start_stream();
    wr(2'd3, 32'h00AA_FF00);
    rd(2'd3, 32'h003C_0301, "R11 locked");
    run_beats(8, 25);
    wr(2'd0, 32'd0);

    // R9 error request before start; R10 count 0 sends no preamble
    cfg_pre(1, 0, 8'hC3);
    wr(2'd1, 32'd0); m_pat = 0;
    wr(2'd2, 32'd1); m_err = 1;
    rd(2'd2, 32'd1, "R8 pending");
    start_stream();
    next_tag = "R9";
    run_beats(1, 0);
    rd(2'd2, 32'd0, "R8 cleared");
    run_beats(10, 40);
    wr(2'd0, 32'd0);

    // R10 long preamble with max count
    cfg_pre(1, 255, 8'h5A);
    wr(2'd1, 32'd3); m_pat = 3;
    start_stream();
    run_beats(300, 10);
    wr(2'd0, 32'd0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int p;
      p = $urandom % 6;
      cfg_pre($urandom % 2, $urandom % 6, SYM_W'($urandom));
      wr(2'd1, p); m_pat = p;
      if ($urandom % 3 == 0) begin wr(2'd2, 32'd1); m_err = 1; next_tag = "R9"; end
      start_stream();
      run_beats(20 + $urandom % 20, $urandom % 60);
      if ($urandom % 2 == 0) begin
        wr(2'd2, 32'd1); m_err = 1;
        run_beats(5, 50);
      end
      if ($urandom % 2 == 0) begin
        p = $urandom % 6;
        wr(2'd1, p); m_pat = p; m_st = '1;
        next_tag = "R7";
        run_beats(30, 30);
      end
      wr(2'd0, 32'd0);
      m_err = 0;
      chk("R12 stop valid", BW'(valid), BW'(0));
      chk("R2 idle", data, IDLE_W);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule